// File: doc/BRIEF.md
# Host Conversion Sequencer

This block sits on the host side of a sampling analog-to-digital converter. It steps the converter through repeated conversion cycles. A pulse on `start_req` asks for one conversion. The sequencer raises `cnv_start` as soon as the converter has been acquiring for long enough. It then decides that the conversion is over in one of two ways. When `use_ready` is high, it watches the converter's ready pin `rdy_in` for a rising edge. When `use_ready` is low, it waits a fixed worst-case conversion time. After each conversion it gives a one-cycle `done` pulse to the downstream serial reader. It then enforces a minimum acquisition time before the next `cnv_start`, so one full cycle is never shorter than the conversion time plus the minimum acquisition time.

The sequencer also produces the converter's reset-release sequence. It holds `cnv_rst_n` low with `cnv_start` low and the serial clock blocked (`sclk_en` low). It then releases the reset and waits for the converter to settle before it allows the first conversion. The settle phase ends on a fixed time in timeout mode, or on a rising edge of `rdy_in` in ready mode. All durations are parameters counted in clock cycles. `rdy_in` passes through a `SYNC_STAGES`-deep synchronizer before its edge is detected.

The block has four states. RST_LOW holds the converter in reset. SETTLE waits after the reset has been released. ACQ is the acquisition phase and the idle state. CONV is a conversion in progress. The transitions are:
- RST_LOW→SETTLE, after `RST_LOW_CYC` cycles.
- SETTLE→ACQ, on the settle time or on a ready rise.
- ACQ→RST_LOW, on `init_req`.
- ACQ→CONV, on a pending or new request once the acquisition minimum has been met.
- CONV→ACQ, on the worst-case time or on a ready rise.

Block reset puts the sequencer in RST_LOW.

Top module: `conv_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `cnv_rst_n`=0, `cnv_start`=0, `sclk_en`=0, `done`=0 and `busy`=1.
- R2: After block reset is released, or after `init_req` is taken in ACQ, `cnv_rst_n` stays low for exactly `RST_LOW_CYC` cycles. `cnv_start` and `sclk_en` are low for that whole time.
- R3: After `cnv_rst_n` rises, `busy` stays high and `cnv_start` and `sclk_en` stay low. In timeout mode (`use_ready`=0) this lasts exactly `SETTLE_CYC` cycles. In ready mode (`use_ready`=1) it lasts until `SYNC_STAGES`+1 cycles after `rdy_in` rises, however long that takes.
- R4: A `start_req` pulse in ACQ, once the acquisition minimum has been met, makes `cnv_start` high in the next cycle.
- R5: In timeout mode, `cnv_start` stays high for exactly `CONV_MAX_CYC` cycles, and `rdy_in` has no effect on it.
- R6: In ready mode, `cnv_start` stays high past `CONV_MAX_CYC` until the `rdy_in` rise. It falls `SYNC_STAGES`+1 cycles after that rise.
- R7: `done` is high for exactly one cycle: the first cycle after `cnv_start` falls.
- R8: Between two conversions, `cnv_start` stays low for at least `ACQ_MIN_CYC` cycles. With a request always waiting, it stays low for exactly `ACQ_MIN_CYC` cycles.
- R9: A request made during CONV, or in ACQ before the minimum has been met, is held pending. It starts a conversion as soon as the minimum is met. Without a request, no conversion starts.
- R10: `busy` is low in ACQ and high in RST_LOW, SETTLE and CONV.
- R11: `init_req` in ACQ enters RST_LOW in the next cycle. It takes priority over a `start_req` in the same cycle, and that start request stays pending until the reset sequence has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, asynchronous, active low |
| start_req | input | 1 | Conversion request (pulse or level) |
| init_req | input | 1 | Request the converter reset-release sequence |
| use_ready | input | 1 | 1: completion from the ready pin; 0: fixed worst-case timeout |
| rdy_in | input | 1 | Converter ready pin, asynchronous |
| cnv_start | output | 1 | Convert-start to the converter, high during CONV |
| cnv_rst_n | output | 1 | Converter reset, active low |
| sclk_en | output | 1 | Serial clock permitted (0 holds it low) |
| done | output | 1 | One-cycle pulse at the end of each conversion |
| busy | output | 1 | High outside the acquisition state |

## Verification
Timing of each result:
- `cnv_start` rises one cycle after an accepted request.
- `done` appears in the same cycle that `cnv_start` is first seen low.
- Ready-pin edges take effect `SYNC_STAGES`+1 cycles after `rdy_in` changes.

Every phase length is measured by counting consecutive samples of an output level, starting from its first sample. The counts must therefore match `RST_LOW_CYC`, `SETTLE_CYC`, `CONV_MAX_CYC` and `ACQ_MIN_CYC` exactly. Inputs change and outputs are sampled only on falling clock edges, so each check falls midway between the rising edges at which the registers update.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        S_RST_LOW = 2'd0,
        S_SETTLE  = 2'd1,
        S_ACQ     = 2'd2,
        S_CONV    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/conv_seq_rdy_sync.sv
// Synchronizes the asynchronous ready pin and flags its rising edge.
module conv_seq_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic lvl;
    logic prev;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = d;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= '0;
                end else begin
                    sh[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sh[i] <= sh[i-1];
                    end
                end
            end
            assign lvl = sh[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/conv_seq_timer.sv
// Phase counter: cleared on every state change, otherwise counts up and saturates.
module conv_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int CONV_MAX_CYC = 40,
    parameter int ACQ_MIN_CYC  = 12,
    parameter int SETTLE_CYC   = 30,
    parameter int RST_LOW_CYC  = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic init_req,
    input  logic use_ready,
    input  logic rdy_in,
    output logic cnv_start,
    output logic cnv_rst_n,
    output logic sclk_en,
    output logic done,
    output logic busy
);
    localparam int MAX_A = (CONV_MAX_CYC > ACQ_MIN_CYC) ? CONV_MAX_CYC : ACQ_MIN_CYC;
    localparam int MAX_B = (SETTLE_CYC > RST_LOW_CYC) ? SETTLE_CYC : RST_LOW_CYC;
    localparam int MAXV  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAXV + 1) + 1;
    localparam logic [CNT_W-1:0] LIM_CONV   = CNT_W'(CONV_MAX_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_ACQ    = CNT_W'(ACQ_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_RST    = CNT_W'(RST_LOW_CYC - 1);

    seq_state_e       st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             rdy_rise;
    logic             pend;
    logic             go_conv;

    conv_seq_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rdy_in),
        .rise (rdy_rise)
    );

    conv_seq_timer #(.W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (nxt != st),
        .cnt  (cnt)
    );

    // Next-state decision
    always_comb begin
        nxt     = st;
        go_conv = 1'b0;
        unique case (st)
            S_RST_LOW: if (cnt == LIM_RST) nxt = S_SETTLE;
            S_SETTLE:  if (use_ready ? rdy_rise : (cnt == LIM_SETTLE)) nxt = S_ACQ;
            S_ACQ: begin
                if (init_req) begin
                    nxt = S_RST_LOW;
                end else if ((pend || start_req) && (cnt >= LIM_ACQ)) begin
                    nxt     = S_CONV;
                    go_conv = 1'b1;
                end
            end
            S_CONV:    if (use_ready ? rdy_rise : (cnt == LIM_CONV)) nxt = S_ACQ;
            default:   nxt = S_RST_LOW;
        endcase
    end

    // State register, pending request and end-of-conversion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_RST_LOW;
            pend <= 1'b0;
            done <= 1'b0;
        end else begin
            st   <= nxt;
            pend <= (pend | start_req) & ~go_conv;
            done <= (st == S_CONV) && (nxt == S_ACQ);
        end
    end

    // Level outputs decoded from state
    always_comb begin
        cnv_start = (st == S_CONV);
        cnv_rst_n = (st != S_RST_LOW);
        sclk_en   = (st == S_ACQ) || (st == S_CONV);
        busy      = (st != S_ACQ);
    end

    // Run-length monitors of the output pins, used by the properties below
    logic [CNT_W-1:0] hi_run, lo_run, rl_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            rl_run <= '0;
        end else begin
            hi_run <= cnv_start ? ((hi_run != '1) ? hi_run + 1'b1 : hi_run) : '0;
            lo_run <= !cnv_start ? ((lo_run != '1) ? lo_run + 1'b1 : lo_run) : '0;
            rl_run <= !cnv_rst_n ? ((rl_run != '1) ? rl_run + 1'b1 : rl_run) : '0;
        end
    end

    p_rst_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_rst_n) |-> (rl_run == CNT_W'(RST_LOW_CYC)));

    p_conv_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnv_start) && !use_ready) |-> (hi_run == CNT_W'(CONV_MAX_CYC)));

    p_done_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cnv_start) && !cnv_start));

    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_acq_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_start) |-> (lo_run >= CNT_W'(ACQ_MIN_CYC)));
endmodule

// File: tb/test_conv_seq.sv
module test_conv_seq;
    localparam int CONV_MAX = 40;
    localparam int ACQ_MIN  = 12;
    localparam int SETTLE   = 30;
    localparam int RST_LOW  = 8;
    localparam int SYNC     = 2;

    logic clk = 1'b0;
    logic rst_n, start_req, init_req, use_ready, rdy_in;
    logic cnv_start, cnv_rst_n, sclk_en, done, busy;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    conv_seq #(
        .CONV_MAX_CYC(CONV_MAX), .ACQ_MIN_CYC(ACQ_MIN), .SETTLE_CYC(SETTLE),
        .RST_LOW_CYC(RST_LOW), .SYNC_STAGES(SYNC)
    ) i_conv_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .init_req(init_req),
        .use_ready(use_ready), .rdy_in(rdy_in), .cnv_start(cnv_start),
        .cnv_rst_n(cnv_rst_n), .sclk_en(sclk_en), .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (cnv_start === 1'b1 && n < 2000) begin n++; tick(); end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (cnv_start === 1'b0 && n < 2000) begin n++; tick(); end
    endtask

    task automatic t_reset_seq();
        int n = 0;
        int m = 0;
        int bad = 0;
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 cnv_rst_n", int'(cnv_rst_n), 0);
        chk("R1 cnv_start", int'(cnv_start), 0);
        chk("R1 sclk_en", int'(sclk_en), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 busy", int'(busy), 1);
        rst_n = 1'b1;
        while (cnv_rst_n === 1'b0 && n < 2000) begin
            if (cnv_start || sclk_en) bad++;
            n++;
            tick();
        end
        chk("R2 reset low width", n, RST_LOW);
        chk("R2 start/sclk low in reset", bad, 0);
        while (busy === 1'b1 && m < 2000) begin
            if (cnv_start || sclk_en || !cnv_rst_n) bad++;
            m++;
            tick();
        end
        chk("R3 settle timeout length", m, SETTLE);
        chk("R3 quiet during settle", bad, 0);
        chk("R10 busy low in ACQ", int'(busy), 0);
    endtask

    task automatic t_timeout_conv();
        int h = 0;
        repeat (ACQ_MIN + 2) tick();
        pulse_start();
        chk("R4 start one cycle after request", int'(cnv_start), 1);
        chk("R10 busy in CONV", int'(busy), 1);
        while (cnv_start === 1'b1 && h < 2000) begin
            h++;
            if (h == 5 || h == 13) rdy_in = 1'b1;
            if (h == 9) rdy_in = 1'b0;
            tick();
        end
        chk("R5 timeout conversion length, ready ignored", h, CONV_MAX);
        chk("R7 done after fall", int'(done), 1);
        chk("R10 busy low after conversion", int'(busy), 0);
        tick();
        chk("R7 done single cycle", int'(done), 0);
        rdy_in = 1'b0;
    endtask

    task automatic t_back_to_back();
        int n;
        int bad = 0;
        start_req = 1'b1;
        count_low(n);
        count_high(n);
        chk("R5 first back-to-back length", n, CONV_MAX);
        count_low(n);
        chk("R8 gap with request waiting", n, ACQ_MIN);
        start_req = 1'b0;
        count_high(n);
        repeat (ACQ_MIN + CONV_MAX) begin
            if (cnv_start) bad++;
            tick();
        end
        chk("R9 no request gives no conversion", bad, 0);
    endtask

    task automatic t_pending();
        int h = 0;
        int g = 0;
        pulse_start();
        while (cnv_start === 1'b1 && h < 2000) begin
            h++;
            start_req = (h == 10);
            tick();
        end
        start_req = 1'b0;
        count_low(g);
        chk("R9 request during CONV kept pending", g, ACQ_MIN);
        count_high(h);
        g = 0;
        while (cnv_start === 1'b0 && g < 2000) begin
            g++;
            start_req = (g == 3);
            tick();
        end
        start_req = 1'b0;
        chk("R9 early request in ACQ kept pending", g, ACQ_MIN);
        count_high(h);
    endtask

    task automatic t_ready_conv();
        int bad = 0;
        use_ready = 1'b1;
        rdy_in = 1'b1;
        repeat (ACQ_MIN + 4) tick();
        pulse_start();
        chk("R4 start in ready mode", int'(cnv_start), 1);
        rdy_in = 1'b0;
        repeat (CONV_MAX + 10) begin
            if (!cnv_start) bad++;
            tick();
        end
        chk("R6 conversion held past timeout", bad, 0);
        rdy_in = 1'b1;
        repeat (SYNC) tick();
        chk("R6 still converting inside sync latency", int'(cnv_start), 1);
        tick();
        chk("R6 ends after ready rise", int'(cnv_start), 0);
        chk("R7 done in ready mode", int'(done), 1);
        tick();
    endtask

    task automatic t_ready_settle();
        int n = 0;
        int bad = 0;
        use_ready = 1'b1;
        rdy_in = 1'b0;
        repeat (4) tick();
        init_req = 1'b1;
        tick();
        init_req = 1'b0;
        chk("R11 init enters reset", int'(cnv_rst_n), 0);
        while (cnv_rst_n === 1'b0 && n < 2000) begin n++; tick(); end
        chk("R2 reset width after init", n, RST_LOW);
        repeat (SETTLE + 10) begin
            if (!busy || !cnv_rst_n || sclk_en) bad++;
            tick();
        end
        chk("R3 ready-mode settle waits for pin", bad, 0);
        rdy_in = 1'b1;
        repeat (SYNC) tick();
        chk("R3 settle inside sync latency", int'(busy), 1);
        tick();
        chk("R3 settle ends on ready rise", int'(busy), 0);
        use_ready = 1'b0;
        rdy_in = 1'b0;
    endtask

    task automatic t_init_priority();
        int n = 0;
        repeat (ACQ_MIN + 2) tick();
        init_req = 1'b1;
        start_req = 1'b1;
        tick();
        init_req = 1'b0;
        start_req = 1'b0;
        chk("R11 init wins: reset low", int'(cnv_rst_n), 0);
        chk("R11 init wins: no start", int'(cnv_start), 0);
        while (busy === 1'b1 && n < 2000) begin n++; tick(); end
        chk("R3 reset plus settle length", n, RST_LOW + SETTLE);
        count_low(n);
        chk("R11 start kept pending through reset", n, ACQ_MIN);
        count_high(n);
        chk("R5 pending conversion length", n, CONV_MAX);
    endtask

    initial begin
        rst_n = 1'b0; start_req = 1'b0; init_req = 1'b0;
        use_ready = 1'b0; rdy_in = 1'b0;
        t_reset_seq();
        t_timeout_conv();
        t_back_to_back();
        t_pending();
        t_ready_conv();
        t_ready_settle();
        t_init_priority();
        repeat (3) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule